// File: doc/BRIEF.md
# Per-Bank Row Timeout Precharge Tracker

This block follows the row buffer of every bank in one DRAM rank. It records which row each bank holds open. It answers hit or conflict lookups for a bank and row. In timeout mode it asks for a precharge once a bank's row has stayed idle longer than the timeout in force for that bank. The scheduler supplies the timeout value. It may change that value from one observation window to the next, for example to pick long holds for busy, local traffic and short holds for sparse, scattered traffic.

The scheduler reports three kinds of event: activates, column accesses and completed precharges. The block answers with a per-bank open mask, one precharge request naming a bank, and an all-banks-closed flag. The power-down controller uses that flag to put the rank into precharge power-down.

A close-page flag makes each column access carry its own auto-precharge. That bank is marked closed at once, with no timer and no request. This is kept apart from a zero timeout. A zero timeout still goes through the request path, so the bank stays open until the precharge is actually done.

Top module: `rowtmo_tracker`

## Requirements
- R1: After reset every bank is closed, `bank_open` is 0, `all_closed` is 1 and `pre_req` is 0.
- R2: An activate sampled on `act_valid` opens bank `act_bank` with row `act_row`, and sets bit `act_bank` of `bank_open` from the next cycle.
- R3: `lkp_hit` is 1 when bank `lkp_bank` is open and holds `lkp_row`. `lkp_conflict` is 1 when that bank is open with a different row. Both are 0 for a closed bank. A bank whose precharge has been acknowledged but not yet completed still counts as open.
- R4: In timeout mode, an access sampled at clock edge n with timeout value T raises `pre_req` for that bank from edge n+T onward. An access is an activate, or a column access to an open bank. Each access restarts the idle timer at zero.
- R5: With a timeout of 0, the request appears in the cycle right after the access.
- R6: The timeout is captured at each access. Changing `timeout_val` afterwards does not move a bank's pending deadline.
- R7: A column access sampled with `close_page` = 1 closes the bank from the next cycle, and no precharge request is raised for it.
- R8: A request stays asserted until `pre_ack` is sampled with it. After the acknowledge the bank leaves the request set but stays open.
- R9: When several banks are requesting, `pre_req_bank` names the lowest-numbered one.
- R10: A column access to a bank whose request is pending withdraws that request and restarts the timer.
- R11: `pre_done` closes bank `pre_done_bank` from the next cycle.
- R12: `all_closed` is 1 exactly when no bank is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activate event |
| act_bank | input | 3 | Bank of the activate |
| act_row | input | 14 | Row opened by the activate |
| cas_valid | input | 1 | Column-access event |
| cas_bank | input | 3 | Bank of the column access |
| close_page | input | 1 | 1: column access carries auto-precharge |
| timeout_val | input | 14 | Idle timeout in cycles, captured at each access |
| pre_done | input | 1 | Precharge completed |
| pre_done_bank | input | 3 | Bank whose precharge completed |
| pre_ack | input | 1 | Accepts the current precharge request |
| lkp_bank | input | 3 | Lookup bank |
| lkp_row | input | 14 | Lookup row |
| lkp_hit | output | 1 | Lookup row is the open row |
| lkp_conflict | output | 1 | Bank open with another row |
| pre_req | output | 1 | Precharge requested |
| pre_req_bank | output | 3 | Bank to precharge |
| bank_open | output | 8 | Per-bank open mask |
| all_closed | output | 1 | No bank holds an open row |

## Verification
The hardest situation to reach is a pending request that outlives the events around it. Reaching it means holding two banks in the request state together, acknowledging one of them, and then sending a column access to the other. The stimulus gets there by issuing zero-timeout accesses to two banks on back-to-back cycles and letting the requests wait unacknowledged. It then acknowledges the lower bank and hits the remaining one. The timeout-capture case is reached by changing `timeout_val` to zero straight after an access and checking that the request still arrives on the original deadline.

// File: rtl/rowtmo_pkg.sv
package rowtmo_pkg;

  typedef enum logic [1:0] {
    BK_CLOSED = 2'd0,
    BK_OPEN   = 2'd1,
    BK_ISSUED = 2'd2
  } bank_st_e;

  // Idle time has reached the captured limit.
  function automatic logic idle_lapsed(input logic [31:0] idle, input logic [31:0] limit);
    return idle >= limit;
  endfunction

  // Mask of the bank positions below idx.
  function automatic logic [31:0] below_mask(input int unsigned idx);
    return (32'd1 << idx) - 32'd1;
  endfunction

endpackage

// File: rtl/rowtmo_bank.sv
module rowtmo_bank
  import rowtmo_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int TMO_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic [ROW_W-1:0] act_row_i,
  input  logic             cas_i,
  input  logic             close_page_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             done_i,
  input  logic             ack_i,
  input  logic [ROW_W-1:0] lkp_row_i,
  output logic             is_open_o,
  output logic             pend_o,
  output logic             match_o
);

  bank_st_e         st_q;
  logic [ROW_W-1:0] row_q;
  logic [TMO_W-1:0] idle_q;
  logic [TMO_W-1:0] lim_q;

  logic live;
  logic lapsed;
  logic cas_live;

  assign live      = (st_q == BK_OPEN);
  assign lapsed    = idle_lapsed(32'(idle_q), 32'(lim_q));
  assign cas_live  = cas_i && live;
  assign is_open_o = (st_q != BK_CLOSED);
  assign pend_o    = live && lapsed;
  assign match_o   = is_open_o && (row_q == lkp_row_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= BK_CLOSED;
      row_q  <= '0;
      idle_q <= '0;
      lim_q  <= '0;
    end else if (act_i) begin
      st_q   <= BK_OPEN;
      row_q  <= act_row_i;
      idle_q <= '0;
      lim_q  <= tmo_i;
    end else if (done_i) begin
      st_q <= BK_CLOSED;
    end else if (cas_live) begin
      if (close_page_i) begin
        st_q <= BK_CLOSED;
      end else begin
        idle_q <= '0;
        lim_q  <= tmo_i;
      end
    end else if (ack_i && pend_o) begin
      st_q <= BK_ISSUED;
    end else if (live && !lapsed) begin
      idle_q <= idle_q + {{(TMO_W-1){1'b0}}, 1'b1};
    end
  end

  // R5
  zero_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_live && !close_page_i && (tmo_i == '0) && !act_i && !done_i) |=> pend_o);

  // R7
  close_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_live && close_page_i && !act_i && !done_i) |=> (!is_open_o && !pend_o));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !ack_i && !cas_i && !act_i && !done_i) |=> pend_o);

  // R10
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_live && !close_page_i && (tmo_i != '0) && !act_i && !done_i) |=> !pend_o);

  // R11
  done_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !act_i) |=> !is_open_o);

  // R8
  ack_keeps_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && pend_o && !act_i && !done_i && !cas_i) |=> (is_open_o && !pend_o));

endmodule

// File: rtl/rowtmo_arb.sv
module rowtmo_arb
  import rowtmo_pkg::*;
#(
  parameter int NB = 8,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] pend_i,
  output logic          req_o,
  output logic [BW-1:0] bank_o,
  output logic [NB-1:0] grant_o
);

  logic found;

  always_comb begin
    grant_o = '0;
    bank_o  = '0;
    found   = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (pend_i[i] && !found) begin
        grant_o[i] = 1'b1;
        bank_o     = BW'(i);
        found      = 1'b1;
      end
    end
  end

  assign req_o = found;

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R9
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (pend_i[bank_o] && ((32'(pend_i) & below_mask(32'(bank_o))) == 32'd0)));

endmodule

// File: rtl/rowtmo_tracker.sv
module rowtmo_tracker
  import rowtmo_pkg::*;
#(
  parameter int NB    = 8,
  parameter int ROW_W = 14,
  parameter int TMO_W = 14,
  localparam int BW   = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_valid,
  input  logic [BW-1:0]    act_bank,
  input  logic [ROW_W-1:0] act_row,
  input  logic             cas_valid,
  input  logic [BW-1:0]    cas_bank,
  input  logic             close_page,
  input  logic [TMO_W-1:0] timeout_val,
  input  logic             pre_done,
  input  logic [BW-1:0]    pre_done_bank,
  input  logic             pre_ack,
  input  logic [BW-1:0]    lkp_bank,
  input  logic [ROW_W-1:0] lkp_row,
  output logic             lkp_hit,
  output logic             lkp_conflict,
  output logic             pre_req,
  output logic [BW-1:0]    pre_req_bank,
  output logic [NB-1:0]    bank_open,
  output logic             all_closed
);

  logic [NB-1:0] pend;
  logic [NB-1:0] match;
  logic [NB-1:0] grant;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic act_sel, cas_sel, done_sel, ack_sel;
    assign act_sel  = act_valid && (act_bank == BW'(g));
    assign cas_sel  = cas_valid && (cas_bank == BW'(g));
    assign done_sel = pre_done && (pre_done_bank == BW'(g));
    assign ack_sel  = pre_ack && grant[g];

    rowtmo_bank #(.ROW_W(ROW_W), .TMO_W(TMO_W)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .act_i        (act_sel),
      .act_row_i    (act_row),
      .cas_i        (cas_sel),
      .close_page_i (close_page),
      .tmo_i        (timeout_val),
      .done_i       (done_sel),
      .ack_i        (ack_sel),
      .lkp_row_i    (lkp_row),
      .is_open_o    (bank_open[g]),
      .pend_o       (pend[g]),
      .match_o      (match[g])
    );
  end

  rowtmo_arb #(.NB(NB), .BW(BW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (pend),
    .req_o   (pre_req),
    .bank_o  (pre_req_bank),
    .grant_o (grant)
  );

  assign lkp_hit      = match[lkp_bank];
  assign lkp_conflict = bank_open[lkp_bank] && !match[lkp_bank];
  assign all_closed   = (bank_open == '0);

  // R12
  closed_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_closed |-> !pre_req);

  // R3
  lookup_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lkp_hit && lkp_conflict));

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> !all_closed);

endmodule

// File: tb/tb_rowtmo_tracker.sv
module tb_rowtmo_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_valid = 1'b0;
  logic [2:0]  act_bank = '0;
  logic [13:0] act_row = '0;
  logic        cas_valid = 1'b0;
  logic [2:0]  cas_bank = '0;
  logic        close_page = 1'b0;
  logic [13:0] timeout_val = '0;
  logic        pre_done = 1'b0;
  logic [2:0]  pre_done_bank = '0;
  logic        pre_ack = 1'b0;
  logic [2:0]  lkp_bank = '0;
  logic [13:0] lkp_row = '0;
  logic        lkp_hit, lkp_conflict, pre_req, all_closed;
  logic [2:0]  pre_req_bank;
  logic [7:0]  bank_open;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rowtmo_tracker dut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_bank(act_bank), .act_row(act_row),
    .cas_valid(cas_valid), .cas_bank(cas_bank), .close_page(close_page),
    .timeout_val(timeout_val), .pre_done(pre_done), .pre_done_bank(pre_done_bank),
    .pre_ack(pre_ack), .lkp_bank(lkp_bank), .lkp_row(lkp_row), .lkp_hit(lkp_hit),
    .lkp_conflict(lkp_conflict), .pre_req(pre_req), .pre_req_bank(pre_req_bank),
    .bank_open(bank_open), .all_closed(all_closed)
  );

  // {bank, row, expected hit, expected conflict}
  localparam logic [18:0] LK_VEC [8] = '{
    {3'd0, 14'h0010, 1'b1, 1'b0},
    {3'd0, 14'h0011, 1'b0, 1'b1},
    {3'd3, 14'h0123, 1'b1, 1'b0},
    {3'd3, 14'h0122, 1'b0, 1'b1},
    {3'd7, 14'h3FFF, 1'b1, 1'b0},
    {3'd7, 14'h0000, 1'b0, 1'b1},
    {3'd2, 14'h0010, 1'b0, 1'b0},
    {3'd5, 14'h0123, 1'b0, 1'b0}
  };

  task automatic chk(input int actual, input int expected, input string req);
    nchk++;
    if (actual != expected) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_act(input int b, input int row, input int tmo);
    act_valid = 1'b1; act_bank = 3'(b); act_row = 14'(row); timeout_val = 14'(tmo);
    tick();
    act_valid = 1'b0;
  endtask

  task automatic do_cas(input int b, input int tmo, input bit cp);
    cas_valid = 1'b1; cas_bank = 3'(b); timeout_val = 14'(tmo); close_page = cp;
    tick();
    cas_valid = 1'b0; close_page = 1'b0;
  endtask

  task automatic do_done(input int b);
    pre_done = 1'b1; pre_done_bank = 3'(b);
    tick();
    pre_done = 1'b0;
  endtask

  task automatic do_ack();
    pre_ack = 1'b1;
    tick();
    pre_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(bank_open, 0, "R1 bank_open");
    chk(all_closed, 1, "R1 all_closed");
    chk(pre_req, 0, "R1 pre_req");

    // R2 activates
    do_act(0, 16'h0010, 3000);
    chk(bank_open, 8'h01, "R2 bank_open");
    do_act(3, 16'h0123, 3000);
    do_act(7, 16'h3FFF, 3000);
    chk(bank_open, 8'h89, "R2 bank_open three");
    chk(all_closed, 0, "R12 all_closed with open banks");

    // R3 lookup table
    foreach (LK_VEC[i]) begin
      lkp_bank = LK_VEC[i][18:16];
      lkp_row  = LK_VEC[i][15:2];
      #1;
      chk(lkp_hit, LK_VEC[i][1], "R3 lkp_hit");
      chk(lkp_conflict, LK_VEC[i][0], "R3 lkp_conflict");
    end

    // R11 close them
    do_done(0);
    chk(bank_open, 8'h88, "R11 bank0 closed");
    do_done(3);
    do_done(7);
    chk(all_closed, 1, "R12 all_closed after done");

    // R4 timeout 4 with restart
    do_act(2, 16'h0042, 3000);
    do_cas(2, 4, 0);
    tick(); tick();
    do_cas(2, 4, 0);
    for (int k = 1; k < 4; k++) begin
      tick();
      chk(pre_req, 0, "R4 no req before deadline");
    end
    tick();
    chk(pre_req, 1, "R4 req at deadline");
    chk(pre_req_bank, 2, "R4 req bank");
    do_ack();
    chk(pre_req, 0, "R8 ack clears req");
    chk(bank_open[2], 1, "R8 acked bank still open");
    do_done(2);
    chk(bank_open[2], 0, "R11 bank2 closed");

    // R5 zero timeout, R9 priority
    do_act(5, 16'h0555, 3000);
    do_cas(5, 0, 0);
    chk(pre_req, 1, "R5 req next cycle");
    chk(pre_req_bank, 5, "R5 req bank");
    do_act(1, 16'h0111, 3000);
    do_cas(1, 0, 0);
    chk(pre_req_bank, 1, "R9 lowest bank first");
    repeat (10) tick();
    chk(pre_req, 1, "R8 req held");
    chk(pre_req_bank, 1, "R8 req bank held");
    do_ack();
    chk(pre_req_bank, 5, "R9 next bank after ack");
    chk(bank_open[1], 1, "R8 bank1 open after ack");
    lkp_bank = 3'd1; lkp_row = 14'h0111; #1;
    chk(lkp_hit, 1, "R3 issued bank still hits");
    do_done(1);

    // R10 cancel pending by access
    do_cas(5, 50, 0);
    chk(pre_req, 0, "R10 cancelled");
    chk(bank_open[5], 1, "R10 bank stays open");

    // R6 timeout captured at access
    do_cas(5, 6, 0);
    timeout_val = 14'd0;
    for (int k = 1; k < 6; k++) begin
      tick();
      chk(pre_req, 0, "R6 deadline unchanged");
    end
    tick();
    chk(pre_req, 1, "R6 req at captured deadline");
    do_ack();
    do_done(5);

    // R7 close page
    do_act(6, 16'h0666, 3000);
    do_cas(6, 0, 1);
    chk(bank_open[6], 0, "R7 closed by auto precharge");
    chk(pre_req, 0, "R7 no request");
    tick();
    chk(pre_req, 0, "R7 still no request");
    chk(all_closed, 1, "R12 all closed at end");

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule